// File: doc/BRIEF.md
# Atomic Clock Source and Half-Integer Divider Controller

This block picks one of several parent tick streams and divides it by a half-integer ratio to produce an output clock-enable strobe and a square-wave level. Each parent tick input pulses at twice its parent's frequency. A raw divider value D therefore gives an output rate of 2 × parent / (D + 1), because every output period spans D + 1 ticks of the selected input.

Software reconfigures the block through two registers. It stages a new source index and divider value in the configuration register, then sets a request bit in the command register. The hardware copies both staged values into the active path together. It does this only on the tick that closes a complete output period, so the output never runs on a mix of old and new settings. When the copy is done, the request bit and the pending flag clear. The command register also reports when the selected source has stopped ticking.

Top module: `clk_mux_div`

## Requirements
- R1: After reset, the command register (offset 0x0) reads 0. The configuration register (offset 0x4) reads source 0 in bits [SRC_SHIFT +: SRC_W] and divider 1 in bits [DIV_SHIFT +: DIV_W]. lvl_o is 1.
- R2: A write to offset 0x4 stages both fields. A read of offset 0x4 returns the staged values. Command bit 4 (pending) reads 1 until the values are applied. The active source and divider stay unchanged until then.
- R3: With active divider D, each output period spans D + 1 ticks of the selected source. lvl_o is 1 during the first ceil((D + 1) / 2) ticks of the period and 0 during the rest. en_o is 1 only in the cycle that carries the last tick of the period.
- R4: Writing 1 to command bit 0 requests an update, and bit 0 reads 1 until the update is applied. In the cycle after the update is applied, bit 0 and bit 4 both read 0.
- R5: An update is applied only in a cycle where en_o is 1 and no register write takes place. In that cycle the new source and the new divider both take effect, and the next period starts from its first tick.
- R6: Writing 0 to command bit 0 before the update is applied cancels the request. The staged values stay pending and the output keeps its old source and divider.
- R7: Command bit 31 reads 1 once the active source has delivered no tick for IDLE_LIMIT consecutive cycles. It reads 0 again in the cycle after a tick arrives.
- R8: Command bit 31 is read-only, and command bits other than 0, 4 and 31 always read 0. A command write never changes bit 31 or the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte address |
| we_i | input | 1 | Write enable, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| tick_i | input | NUM_SRC | Parent tick pulses, one bit per source |
| en_o | output | 1 | Output clock-enable strobe, one per output period |
| lvl_o | output | 1 | Output square-wave level |

## Verification
The assertions assume that the tick inputs are synchronous single-cycle samples in the block's clock domain. They also assume that every register write lasts exactly one cycle, so that a write and an update boundary can be told apart cycle by cycle. The stimulus drives every input on the falling edge. It holds all ticks low while a write is in progress, so each divider pattern starts from a known first tick. Ticks go only to the source under test, which shows that the unselected inputs have no effect.

// File: rtl/md_pkg.sv
package md_pkg;
  localparam int unsigned CMD_OFS      = 0;
  localparam int unsigned CFG_OFS      = 4;
  localparam int unsigned CMD_REQ_BIT  = 0;
  localparam int unsigned CMD_PEND_BIT = 4;
  localparam int unsigned CMD_OFF_BIT  = 31;
endpackage

// File: rtl/md_regs.sv
module md_regs #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE      = 0,
  parameter int unsigned SRC_W     = 2,
  parameter int unsigned DIV_W     = 5,
  parameter int unsigned SRC_SHIFT = 0,
  parameter int unsigned DIV_SHIFT = 8,
  parameter int unsigned RST_DIV   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              apply_i,
  input  logic              root_off_i,
  output logic [31:0]       rdata_o,
  output logic              req_o,
  output logic              pend_o,
  output logic [SRC_W-1:0]  stg_src_o,
  output logic [DIV_W-1:0]  stg_div_o
);
  import md_pkg::*;

  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(BASE + CMD_OFS);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(BASE + CFG_OFS);

  logic cmd_wr, cfg_wr;
  assign cmd_wr = we_i && (addr_i == CMD_ADDR);
  assign cfg_wr = we_i && (addr_i == CFG_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o     <= 1'b0;
      pend_o    <= 1'b0;
      stg_src_o <= '0;
      stg_div_o <= DIV_W'(RST_DIV);
    end else begin
      // apply_i is never high in a write cycle
      if (apply_i)     req_o <= 1'b0;
      else if (cmd_wr) req_o <= wdata_i[CMD_REQ_BIT];
      if (apply_i)     pend_o <= 1'b0;
      else if (cfg_wr) pend_o <= 1'b1;
      if (cfg_wr) begin
        stg_src_o <= wdata_i[SRC_SHIFT +: SRC_W];
        stg_div_o <= wdata_i[DIV_SHIFT +: DIV_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CMD_ADDR) begin
      rdata_o[CMD_REQ_BIT]  = req_o;
      rdata_o[CMD_PEND_BIT] = pend_o;
      rdata_o[CMD_OFF_BIT]  = root_off_i;
    end else if (addr_i == CFG_ADDR) begin
      rdata_o[SRC_SHIFT +: SRC_W] = stg_src_o;
      rdata_o[DIV_SHIFT +: DIV_W] = stg_div_o;
    end
  end
endmodule

// File: rtl/md_divider.sv
module md_divider #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned SRC_W   = 2,
  parameter int unsigned DIV_W   = 5,
  parameter int unsigned RST_DIV = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] tick_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [SRC_W-1:0]   stg_src_i,
  input  logic [DIV_W-1:0]   stg_div_i,
  output logic               apply_o,
  output logic               sel_tick_o,
  output logic               en_o,
  output logic               lvl_o,
  output logic [SRC_W-1:0]   act_src_o,
  output logic [DIV_W-1:0]   act_div_o,
  output logic [DIV_W-1:0]   cnt_o
);
  logic [NUM_SRC-1:0] hit;
  logic               period_end;
  logic [DIV_W:0]     high_len;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
    assign hit[i] = tick_i[i] && (act_src_o == SRC_W'(i));
  end

  assign sel_tick_o = |hit;
  assign period_end = sel_tick_o && (cnt_o == act_div_o);
  assign en_o       = period_end;
  assign apply_o    = req_i && period_end && !we_i;
  assign high_len   = ({1'b0, act_div_o} + (DIV_W+1)'(2)) >> 1;
  assign lvl_o      = ({1'b0, cnt_o} < high_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_src_o <= '0;
      act_div_o <= DIV_W'(RST_DIV);
      cnt_o     <= '0;
    end else if (apply_o) begin
      act_src_o <= stg_src_i;
      act_div_o <= stg_div_i;
      cnt_o     <= '0;
    end else if (sel_tick_o) begin
      cnt_o <= period_end ? '0 : cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/md_idle.sv
module md_idle #(
  parameter int unsigned LIMIT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_tick_i,
  input  logic restart_i,
  output logic root_off_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        idle_q <= '0;
    else if (sel_tick_i || restart_i)   idle_q <= '0;
    else if (idle_q != LIM)             idle_q <= idle_q + 1'b1;
  end

  assign root_off_o = (idle_q == LIM);
endmodule

// File: rtl/clk_mux_div.sv
module clk_mux_div #(
  parameter int unsigned NUM_SRC    = 4,
  parameter int unsigned DIV_W      = 5,
  parameter int unsigned SRC_SHIFT  = 0,
  parameter int unsigned DIV_SHIFT  = 8,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BASE       = 0,
  parameter int unsigned IDLE_LIMIT = 32,
  parameter int unsigned RST_DIV    = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC-1:0] tick_i,
  output logic               en_o,
  output logic               lvl_o
);
  localparam int unsigned SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic             req, pend, apply, sel_tick, root_off;
  logic [SRC_W-1:0] stg_src, act_src;
  logic [DIV_W-1:0] stg_div, act_div, cnt;

  md_regs #(
    .ADDR_W(ADDR_W), .BASE(BASE), .SRC_W(SRC_W), .DIV_W(DIV_W),
    .SRC_SHIFT(SRC_SHIFT), .DIV_SHIFT(DIV_SHIFT), .RST_DIV(RST_DIV)
  ) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .apply_i(apply), .root_off_i(root_off), .rdata_o,
    .req_o(req), .pend_o(pend), .stg_src_o(stg_src), .stg_div_o(stg_div)
  );

  md_divider #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .DIV_W(DIV_W), .RST_DIV(RST_DIV)
  ) u_div (
    .clk_i, .rst_ni, .tick_i, .req_i(req), .we_i,
    .stg_src_i(stg_src), .stg_div_i(stg_div),
    .apply_o(apply), .sel_tick_o(sel_tick), .en_o, .lvl_o,
    .act_src_o(act_src), .act_div_o(act_div), .cnt_o(cnt)
  );

  md_idle #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk_i, .rst_ni, .sel_tick_i(sel_tick), .restart_i(apply),
    .root_off_o(root_off)
  );
endmodule

// File: rtl/clk_mux_div_chk.sv
module clk_mux_div_chk #(
  parameter int unsigned SRC_W = 2,
  parameter int unsigned DIV_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             req_i,
  input logic             pend_i,
  input logic             apply_i,
  input logic             en_i,
  input logic             sel_tick_i,
  input logic             root_off_i,
  input logic [SRC_W-1:0] act_src_i,
  input logic [DIV_W-1:0] act_div_i,
  input logic [DIV_W-1:0] cnt_i
);
  assert_apply_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |=> (!req_i && !pend_i));

  assert_apply_at_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |-> (en_i && !we_i));

  assert_no_mixed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> ($stable(act_src_i) && $stable(act_div_i)));

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= act_div_i);

  assert_req_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !apply_i && !we_i) |=> req_i);

  assert_pend_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !apply_i) |=> pend_i);

  assert_alive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_tick_i |=> !root_off_i);
endmodule

bind clk_mux_div clk_mux_div_chk #(.SRC_W(SRC_W), .DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .req_i(req), .pend_i(pend),
  .apply_i(apply), .en_i(en_o), .sel_tick_i(sel_tick), .root_off_i(root_off),
  .act_src_i(act_src), .act_div_i(act_div), .cnt_i(cnt)
);

// File: tb/sim_clk_mux_div.sv
`timescale 1ns/1ps
module sim_clk_mux_div;
  localparam int NSRC = 4;
  localparam int IDLE = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NSRC-1:0] tick = '0;
  logic        en, lvl;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  clk_mux_div #(.NUM_SRC(NSRC), .IDLE_LIMIT(IDLE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .en_o(en), .lvl_o(lvl)
  );

  function automatic logic [31:0] cfg(int src, int dv);
    return (32'(dv) << 8) | 32'(src);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    tick = '0; addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    tick = '0; addr = a;
    #1 d = rdata;
  endtask

  task automatic tick_cycle(int src, output logic e, output logic l);
    @(negedge clk);
    tick = '0;
    tick[src] = 1'b1;
    #1 e = en; l = lvl;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      tick = '0;
    end
  endtask

  task automatic pattern(string req, int src, int dv, int periods);
    logic e, l;
    for (int p = 0; p < periods; p++) begin
      for (int k = 0; k <= dv; k++) begin
        tick_cycle(src, e, l);
        check({req, " lvl"}, 32'(l), 32'(k < (dv + 2) / 2));
        check({req, " en"}, 32'(e), 32'(k == dv));
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h0, d); check("R1 cmd", d, 32'h0);
    rd(8'h4, d); check("R1 cfg", d, cfg(0, 1));
    check("R1 lvl", 32'(lvl), 32'h1);
  endtask

  task automatic t_default_div();
    pattern("R3 div1", 0, 1, 2);
  endtask

  task automatic t_stage();
    logic [31:0] d;
    wr(8'h4, cfg(2, 4));
    rd(8'h4, d); check("R2 cfg readback", d, cfg(2, 4));
    rd(8'h0, d); check("R2 pending", d, 32'h10);
    pattern("R2 old active", 0, 1, 2);
  endtask

  task automatic t_update();
    logic [31:0] d;
    logic e, l;
    wr(8'h0, 32'h1);
    rd(8'h0, d); check("R4 req set", d, 32'h11);
    tick_cycle(0, e, l);
    check("R5 no early en", 32'(e), 32'h0);
    rd(8'h0, d); check("R5 held mid-period", d, 32'h11);
    tick_cycle(0, e, l);
    check("R5 boundary en", 32'(e), 32'h1);
    rd(8'h0, d); check("R4 cleared", d, 32'h0);
    pattern("R5 new src div4", 2, 4, 2);
  endtask

  task automatic t_cancel();
    logic [31:0] d;
    wr(8'h4, cfg(1, 2));
    wr(8'h0, 32'h1);
    wr(8'h0, 32'h0);
    rd(8'h0, d); check("R6 cancelled", d, 32'h10);
    pattern("R6 unchanged", 2, 4, 2);
    rd(8'h0, d); check("R6 still pending", d, 32'h10);
    wr(8'h0, 32'h1);
    pattern("R5 last old period", 2, 4, 1);
    rd(8'h0, d); check("R4 cleared again", d, 32'h0);
    pattern("R3 div2 src1", 1, 2, 2);
  endtask

  task automatic t_root_off();
    logic [31:0] d;
    logic e, l;
    idle(8);
    rd(8'h0, d); check("R7 not yet off", d, 32'h0);
    idle(IDLE + 4);
    rd(8'h0, d); check("R7 off", d, 32'h8000_0000);
    tick_cycle(2, e, l);
    rd(8'h0, d); check("R7 other src ignored", d, 32'h8000_0000);
    tick_cycle(1, e, l);
    rd(8'h0, d); check("R7 back on", d, 32'h0);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    idle(IDLE + 4);
    wr(8'h0, 32'h7FFF_FFEE);
    rd(8'h0, d); check("R8 ro bits", d, 32'h8000_0000);
    wr(8'h0, 32'h0);
    rd(8'h0, d); check("R8 off kept", d, 32'h8000_0000);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default_div();
    t_stage();
    t_update();
    t_cancel();
    t_root_off();
    t_readonly();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule